// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs the two-wire management link to an external Ethernet PHY. Given a 5-bit PHY address and a 5-bit register address, it builds a complete management frame on MDC/MDIO and either writes a 16-bit value into that PHY register or reads one back. MDIO is modelled as three signals: a driven value, an output enable and a sampled input. When the enable is low, the pad is released.

A single command pulse starts a read or a write. A level-sensitive scan enable reads one register over and over, with no gap between frames, so that software always has a fresh copy of a status register. The 32-bit preamble can be left out for PHYs that accept short frames. The MDC frequency is a fixed fraction of the system clock, chosen with a small select field.

The control core is a five-state machine:
- **IDLE**: MDIO is released and MDC is low.
- **PREAMBLE**: leaving IDLE on a command enters this state, or **HEADER** when suppression is set.
- **HEADER**: the start pattern, the opcode and both addresses.
- **TURN**: entered from HEADER after the last register-address bit.
- **DATA**: entered from TURN after the two turnaround bits.

When DATA ends, the machine goes back to PREAMBLE (or HEADER) if a scan is still enabled. Otherwise it returns to IDLE.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, and whenever no operation runs, `busy`=0, `mdc`=0, `mdio_oe`=0 and `rd_invalid`=0. MDIO is released while idle.
- R2: A write frame sends the following bits, MSB first in every field, with `mdio_oe`=1 throughout: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data bits.
- R3: A read frame sends the same preamble, start and addresses with opcode 10. It releases MDIO (`mdio_oe`=0) from the first turnaround bit to the end of the frame. It samples the 16 data bits, MSB first, on rising MDC. The word appears on `rd_data` at the frame's last falling MDC edge.
- R4: With `no_preamble`=1 at the start of a frame, the frame has no preamble: its first MDC cycle carries the start pattern, for a total of 32 bits.
- R5: Each MDC high phase and each MDC low phase lasts 2*(`clk_div_sel`+1) system clock cycles.
- R6: The master changes `mdio_o` and `mdio_oe` only on the falling MDC edge, never while MDC is high.
- R7: `busy` rises in the cycle after an accepted command. It falls only together with the final falling MDC edge of the last frame.
- R8: `rd_cmd` and `wr_cmd` pulses that arrive while `busy`=1 are ignored. No further frame follows, and `rd_invalid` and `rd_data` are untouched.
- R9: While `scan_en`=1, read frames of the held addresses repeat back to back with `busy` staying high. `rd_data` is refreshed at the end of every frame. `rd_invalid` is set when the scan starts and clears when the first scan read completes.
- R10: Dropping `scan_en` mid-frame lets the current frame finish. `busy` clears only at that frame's end.
- R11: When commands coincide in idle, the priority is scan over read over write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Target PHY address, held while busy |
| reg_addr | input | 5 | Target register address, held while busy |
| wr_data | input | 16 | Data for a write frame |
| rd_cmd | input | 1 | One-cycle pulse: start a read |
| wr_cmd | input | 1 | One-cycle pulse: start a write |
| scan_en | input | 1 | Level: repeat reads while high |
| no_preamble | input | 1 | Omit the 32-bit preamble |
| clk_div_sel | input | 3 | MDC divider select, half period 2*(sel+1) clocks |
| rd_data | output | 16 | Last word read from the PHY |
| busy | output | 1 | Frame in progress |
| rd_invalid | output | 1 | A read is pending and `rd_data` is not yet fresh |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
A bus-functional PHY model watches MDC and answers read frames with a chosen word. Every frame bit and every enable bit is compared against the frame built from the requirements. The frames used are:
- writes and reads at two divider settings, which separates correct field order from the half-period count;
- a short frame without preamble, which shows that the index starts at the start pattern rather than a truncated preamble;
- a three-frame scan with a different answer each time, which shows per-frame refresh and the single clearing of the not-valid flag, and is cancelled inside its last frame.

Commands that are ignored, and commands that coincide, are checked through later port state: no extra frame, an unchanged read word, and a read frame winning over a write.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Frame constants fixed by the management protocol
    localparam int        PRE_BITS = 32;
    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
// Divides the system clock into MDC and flags each MDC edge one cycle wide.
module mdio_clkgen #(
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 mdc,
    output logic                 rise_tick,
    output logic                 fall_tick
);
    localparam int CNT_W = DIV_SEL_W + 2;

    logic [DIV_SEL_W-1:0] sel_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     half_m1;
    logic                 terminal;

    // half period = 2*(sel+1) cycles, so terminal count = 2*sel+1
    assign half_m1   = {1'b0, sel_q, 1'b1};
    assign terminal  = en && (cnt_q == half_m1);
    assign rise_tick = terminal && !mdc;
    assign fall_tick = terminal && mdc;

    // divider select is captured only while idle so a frame keeps one rate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (!en) begin
            sel_q <= div_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_sequencer.sv
// Frame state machine: builds the bit stream and steers MDIO direction.
module mdio_sequencer
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    input  logic              scan_en,
    input  logic              no_pre,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_tick,
    input  logic              fall_tick,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_begin,
    output logic              sample_en,
    output logic              rd_commit
);
    localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int HDR_FIRST  = PRE_BITS;
    localparam int TA_FIRST   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int DATA_FIRST = TA_FIRST + 2;

    localparam logic [IDX_W-1:0] LAST_I    = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] HDR_I     = IDX_W'(HDR_FIRST);
    localparam logic [IDX_W-1:0] HDR_END_I = IDX_W'(TA_FIRST - 1);
    localparam logic [IDX_W-1:0] TA_END_I  = IDX_W'(DATA_FIRST - 1);
    localparam logic [IDX_W-1:0] PRE_END_I = IDX_W'(PRE_BITS - 1);

    mdio_state_e           state_q, state_d;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] frame_q;
    logic                  is_read_q;
    logic                  scan_q;

    logic start_any, start_read, frame_end, continue_scan, load;
    logic [IDX_W-1:0] bit_sel;

    assign start_read    = scan_en || rd_cmd;
    assign start_any     = start_read || wr_cmd;
    assign frame_end     = fall_tick && (idx_q == LAST_I);
    assign continue_scan = scan_q && scan_en;
    assign load          = ((state_q == ST_IDLE) && start_any) ||
                           ((state_q == ST_DATA) && frame_end && continue_scan);
    assign bit_sel       = LAST_I - idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_any) begin
                    state_d = no_pre ? ST_HEADER : ST_PREAMBLE;
                end
            end
            ST_PREAMBLE: begin
                if (fall_tick && idx_q == PRE_END_I) begin
                    state_d = ST_HEADER;
                end
            end
            ST_HEADER: begin
                if (fall_tick && idx_q == HDR_END_I) begin
                    state_d = ST_TURN;
                end
            end
            ST_TURN: begin
                if (fall_tick && idx_q == TA_END_I) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (frame_end) begin
                    if (continue_scan) begin
                        state_d = no_pre ? ST_HEADER : ST_PREAMBLE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame datapath: bit index, frame image, operation kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            frame_q   <= '0;
            is_read_q <= 1'b0;
            scan_q    <= 1'b0;
        end else if (load) begin
            idx_q     <= no_pre ? HDR_I : '0;
            frame_q   <= {{PRE_BITS{1'b1}}, SOF_PAT, (start_read ? OP_RD : OP_WR),
                          phy_addr, reg_addr, TA_WR, wr_data};
            is_read_q <= start_read;
            scan_q    <= scan_en;
        end else if (fall_tick && state_q != ST_IDLE) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mdio_o    = busy ? frame_q[bit_sel] : 1'b0;
        if (is_read_q) begin
            mdio_oe = (state_q == ST_PREAMBLE) || (state_q == ST_HEADER);
        end else begin
            mdio_oe = busy;
        end
        rd_begin  = (state_q == ST_IDLE) && start_read;
        sample_en = rise_tick && (state_q == ST_DATA) && is_read_q;
        rd_commit = frame_end && (state_q == ST_DATA) && is_read_q;
    end

endmodule

// File: rtl/mdio_rx_capture.sv
// Shifts in read data MSB first and publishes it at the frame end.
module mdio_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    input  logic              rd_begin,
    input  logic              sample_en,
    input  logic              rd_commit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_invalid
);
    logic [DATA_W-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (sample_en) begin
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data    <= '0;
            rd_invalid <= 1'b0;
        end else if (rd_commit) begin
            rd_data    <= shift_q;
            rd_invalid <= 1'b0;
        end else if (rd_begin) begin
            rd_invalid <= 1'b1;
        end
    end

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int DIV_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    phy_addr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_cmd,
    input  logic                 wr_cmd,
    input  logic                 scan_en,
    input  logic                 no_preamble,
    input  logic [DIV_SEL_W-1:0] clk_div_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 rd_invalid,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);
    logic rise_tick, fall_tick;
    logic rd_begin, sample_en, rd_commit;

    mdio_clkgen #(.DIV_SEL_W(DIV_SEL_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .div_sel   (clk_div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_cmd    (rd_cmd),
        .wr_cmd    (wr_cmd),
        .scan_en   (scan_en),
        .no_pre    (no_preamble),
        .phy_addr  (phy_addr),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_begin  (rd_begin),
        .sample_en (sample_en),
        .rd_commit (rd_commit)
    );

    mdio_rx_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdio_i     (mdio_i),
        .rd_begin   (rd_begin),
        .sample_en  (sample_en),
        .rd_commit  (rd_commit),
        .rd_data    (rd_data),
        .rd_invalid (rd_invalid)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic rd_cmd,
    input logic wr_cmd,
    input logic scan_en,
    input logic rd_invalid
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R6
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_cmd || wr_cmd || scan_en)) |=> busy);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(mdc));

    // R3
    rd_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_cmd || scan_en)) |=> rd_invalid);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .scan_en    (scan_en),
    .rd_invalid (rd_invalid)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;
    logic        scan_en = 1'b0;
    logic        no_preamble = 1'b0;
    logic [2:0]  clk_div_sel = '0;
    logic [15:0] rd_data;
    logic        busy, rd_invalid, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .scan_en(scan_en),
        .no_preamble(no_preamble), .clk_div_sel(clk_div_sel), .rd_data(rd_data),
        .busy(busy), .rd_invalid(rd_invalid), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        logic [63:0] bits;     // frame bit i at [63-i]
        logic [63:0] oe;
        int          first;
        bit          is_read;
        logic [15:0] phy_val;
    } frame_t;

    frame_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic frame_t build(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d, input bit nopre, input logic [15:0] pv);
        frame_t f;
        f.bits    = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, d};
        f.oe      = rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
        f.first   = nopre ? 32 : 0;
        f.is_read = rd;
        f.phy_val = pv;
        return f;
    endfunction

    // Monitor / PHY model: pops expected frames and compares as MDC runs
    initial begin
        forever begin
            frame_t it;
            int errs;
            logic [63:0] first_bad;
            wait (exp_q.size() > 0);
            it = exp_q[0];
            errs = 0;
            first_bad = 64'hFF;
            for (int i = it.first; i < 64; i++) begin
                @(posedge mdc);
                @(negedge clk);
                if (mdio_oe !== it.oe[63-i] ||
                    (it.oe[63-i] && mdio_o !== it.bits[63-i])) begin
                    errs++;
                    if (first_bad == 64'hFF) first_bad = 64'(i);
                end
                @(negedge mdc);
                @(negedge clk);
                if (it.is_read && i + 1 == 47) mdio_i = 1'b0;
                else if (it.is_read && i + 1 >= 48 && i + 1 < 64) mdio_i = it.phy_val[63-(i+1)];
                else mdio_i = 1'b1;
            end
            // R2 R3 R4: every bit and enable of the frame
            chk(errs == 0, it.is_read ? "R3" : "R2", "frame bit mismatches (first idx)",
                first_bad, 64'hFF);
            if (it.is_read) begin
                // R3 R9: data published at frame end, not-valid cleared
                chk(rd_data === it.phy_val, "R3", "rd_data after frame", 64'(rd_data), 64'(it.phy_val));
                chk(rd_invalid === 1'b0, "R9", "rd_invalid after read", 64'(rd_invalid), 0);
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || busy);
    endtask

    task automatic pulse(input bit rd);
        @(negedge clk);
        if (rd) rd_cmd = 1'b1; else wr_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d,
                            input bit nopre);
        phy_addr = pa; reg_addr = ra; wr_data = d; no_preamble = nopre;
        exp_q.push_back(build(1'b0, pa, ra, d, nopre, 16'h0));
        pulse(1'b0);
    endtask

    task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pv,
                           input bit nopre);
        phy_addr = pa; reg_addr = ra; no_preamble = nopre;
        exp_q.push_back(build(1'b1, pa, ra, 16'h0, nopre, pv));
        pulse(1'b1);
    endtask

    task automatic measure_half(output int hi);
        hi = 0;
        @(posedge mdc);
        @(negedge clk);
        while (mdc) begin
            hi++;
            @(negedge clk);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hp;
        int busy_gaps;
        logic [15:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1", "busy after reset", 64'(busy), 0);
        chk(mdc === 1'b0, "R1", "mdc after reset", 64'(mdc), 0);
        chk(mdio_oe === 1'b0, "R1", "mdio_oe after reset", 64'(mdio_oe), 0);
        chk(rd_invalid === 1'b0, "R1", "rd_invalid after reset", 64'(rd_invalid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 + R5: write at sel=0
        clk_div_sel = 3'd0;
        do_write(5'h13, 5'h0A, 16'hA53C, 1'b0);
        measure_half(hp);
        chk(hp == 2, "R5", "mdc high phase sel=0", 64'(hp), 2);
        drain();
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "idle after write", {mdc, mdio_oe}, 0);

        // R3 + R5: read at sel=3
        clk_div_sel = 3'd3;
        do_read(5'h01, 5'h1F, 16'h8E71, 1'b0);
        repeat (2) @(negedge clk);
        chk(rd_invalid === 1'b1, "R3", "rd_invalid during read", 64'(rd_invalid), 1);
        measure_half(hp);
        chk(hp == 8, "R5", "mdc high phase sel=3", 64'(hp), 8);
        drain();

        // R4: short frames
        clk_div_sel = 3'd0;
        do_write(5'h1C, 5'h03, 16'h0FF1, 1'b1);
        drain();
        do_read(5'h07, 5'h11, 16'h6A96, 1'b1);
        drain();
        no_preamble = 1'b0;

        // R8: commands while busy ignored
        keep = rd_data;
        do_write(5'h02, 5'h04, 16'h1234, 1'b0);
        repeat (20) @(negedge clk);
        rd_cmd = 1'b1; wr_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        drain();
        repeat (30) @(negedge clk);
        chk(busy === 1'b0 && mdc === 1'b0, "R8", "no frame after ignored cmds", {busy, mdc}, 0);
        chk(rd_invalid === 1'b0, "R8", "rd_invalid untouched", 64'(rd_invalid), 0);
        chk(rd_data === keep, "R8", "rd_data untouched", 64'(rd_data), 64'(keep));

        // R11: read wins over a simultaneous write
        phy_addr = 5'h0B; reg_addr = 5'h15; wr_data = 16'hFFFF;
        exp_q.push_back(build(1'b1, 5'h0B, 5'h15, 16'h0, 1'b0, 16'h3C5A));
        @(negedge clk);
        rd_cmd = 1'b1; wr_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        drain();
        chk(rd_data === 16'h3C5A, "R11", "read taken over write", 64'(rd_data), 64'h3C5A);

        // R9 + R10: scan of three frames, cancelled inside the third
        phy_addr = 5'h10; reg_addr = 5'h01;
        exp_q.push_back(build(1'b1, 5'h10, 5'h01, 16'h0, 1'b0, 16'h1111));
        exp_q.push_back(build(1'b1, 5'h10, 5'h01, 16'h0, 1'b0, 16'hC0DE));
        exp_q.push_back(build(1'b1, 5'h10, 5'h01, 16'h0, 1'b0, 16'h7E81));
        @(negedge clk);
        scan_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_invalid === 1'b1, "R9", "rd_invalid at scan start", 64'(rd_invalid), 1);
        busy_gaps = 0;
        while (exp_q.size() > 1) begin
            @(negedge clk);
            if (!busy) busy_gaps++;
        end
        chk(busy_gaps == 0, "R9", "busy gaps between scan frames", 64'(busy_gaps), 0);
        repeat (10) @(negedge clk);
        scan_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy === 1'b1, "R10", "busy held after cancel", 64'(busy), 1);
        drain();
        repeat (30) @(negedge clk);
        chk(busy === 1'b0, "R10", "idle after cancelled scan", 64'(busy), 0);
        chk(rd_data === 16'h7E81, "R9", "last scan word", 64'(rd_data), 64'h7E81);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule